// File: doc/BRIEF.md
# Cascadable Divide-by-N Down Counter

This block is a small binary down counter intended for frequency division. It runs entirely on one system clock. Two asynchronous count-request pins are brought into that clock domain through multi-stage synchronizers. The counter then watches them for edges. The first pin requests a decrement on its rising edge, but only while the second pin sits low. The second pin requests a decrement on its falling edge, but only while the first pin sits high. Each pin therefore acts as an enable for the other.

A parallel value can be loaded with a strobe, and a master reset clears the count. A decoded terminal-count flag is raised when the count is zero. The flag is qualified by a cascade feedback input and by the load strobe. The cascade input lets several stages be chained into a wider divider with no glue logic. In single-stage use, the terminal-count flag is fed back to the load strobe through one register. The counter then reloads its preset each time it reaches zero, which divides the count-edge rate by the preset value.

Top module: `dcnt_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 at that edge. This holds regardless of `load`, `pdata` or any count edge.
- R2: While `load` is high and `rst` is low, each clock edge copies `pdata` into `count`. Count edges arriving during that time are discarded.
- R3: A low-to-high transition on `tick_rise`, made while `tick_fall` is low and `load` is low, decrements `count` by one. The new value appears at the third rising clock edge after the input changes.
- R4: A high-to-low transition on `tick_fall`, made while `tick_rise` is high and `load` is low, decrements `count` by one, with the same latency as R3.
- R5: The count does not change in four cases: a rising `tick_rise` edge while `tick_fall` is high, a falling `tick_fall` edge while `tick_rise` is low, a falling `tick_rise` edge, and a rising `tick_fall` edge.
- R6: `tc` is high exactly when `count` is 0, `cflag` is high and `load` is low. It follows `cflag` and `load` within the same cycle.
- R7: Successive decrements step the count down through plain binary. After 0 the next decrement gives 2**W-1 (15 at the default width).
- R8: With `load` driven from `tc` through one register and a preset of N (1 to 15), `tc` rises once every N qualified count edges. The count then returns to N.
- R9: If qualified edges on both count inputs are seen in the same system clock cycle, `count` drops by exactly one.
- R10: Input levels held through reset cause no decrement when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| load | input | 1 | Parallel load strobe, active high |
| pdata | input | W | Preset value |
| cflag | input | 1 | Cascade feedback qualifier for terminal count |
| tick_rise | input | 1 | Count request on rising edge (asynchronous) |
| tick_fall | input | 1 | Count request on falling edge (asynchronous) |
| count | output | W | Current count |
| tc | output | 1 | Terminal count flag |

## Verification
On every cycle, the assertions check the following: reset clearing, load capture, the terminal-count qualification, and the rule that the count moves by at most one step downward (with wrap) when neither reset nor load is active. That last rule covers the single decrement for simultaneous edges. Only the bench scenarios can show which edge polarity and gating level actually produce a decrement, the three-cycle synchronizer latency, the absence of a count after reset release, and the divide-by-N period under registered feedback.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_PRESET = 2'd2,
        OP_DEC   = 2'd3
    } dcnt_op_e;

    typedef struct packed {
        logic lvl;
        logic rose;
        logic fell;
    } edge_info_t;

    function automatic dcnt_op_e pick_op(input logic clr, input logic ld, input logic step);
        if (clr)       return OP_CLEAR;
        else if (ld)   return OP_PRESET;
        else if (step) return OP_DEC;
        else           return OP_HOLD;
    endfunction

    // rise pin counts on rising edge when the fall pin is low;
    // fall pin counts on falling edge when the rise pin is high.
    function automatic logic want_step(input edge_info_t r, input edge_info_t f);
        return (r.rose && !f.lvl) || (f.fell && r.lvl);
    endfunction

endpackage

// File: rtl/dcnt_sync_edge.sv
module dcnt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic                   clk,
    input  logic                   din,
    output dcnt_pkg::edge_info_t   info
);
    localparam int S = (STAGES < 2) ? 2 : STAGES;

    logic [S-1:0] chain;
    logic         prev;

    always_ff @(posedge clk) begin
        chain <= {chain[S-2:0], din};
        prev  <= chain[S-1];
    end

    always_comb begin
        info.lvl  = chain[S-1];
        info.rose = chain[S-1] && !prev;
        info.fell = !chain[S-1] && prev;
    end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
    parameter int W = 4
) (
    input  logic         clk,
    input  dcnt_pkg::dcnt_op_e op,
    input  logic [W-1:0] pdata,
    output logic [W-1:0] count
);
    import dcnt_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR:  count <= '0;
            OP_PRESET: count <= pdata;
            OP_DEC:    count <= count - ONE;
            default:   count <= count;
        endcase
    end
endmodule

// File: rtl/dcnt_tc.sv
module dcnt_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] count,
    input  logic         cflag,
    input  logic         load,
    output logic         tc
);
    always_comb tc = (count == '0) && cflag && !load;
endmodule

// File: rtl/dcnt_top.sv
module dcnt_top #(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] pdata,
    input  logic         cflag,
    input  logic         tick_rise,
    input  logic         tick_fall,
    output logic [W-1:0] count,
    output logic         tc
);
    import dcnt_pkg::*;

    localparam int NPINS = 2;

    logic [NPINS-1:0] pins;
    edge_info_t       pin_info [NPINS];
    logic             step;
    dcnt_op_e         op;

    assign pins = {tick_fall, tick_rise};

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_sync
        dcnt_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
            .clk  (clk),
            .din  (pins[gi]),
            .info (pin_info[gi])
        );
    end

    always_comb begin
        step = want_step(pin_info[0], pin_info[1]);
        op   = pick_op(rst, load, step);
    end

    dcnt_core #(.W(W)) u_core (
        .clk   (clk),
        .op    (op),
        .pdata (pdata),
        .count (count)
    );

    dcnt_tc #(.W(W)) u_tc (
        .count (count),
        .cflag (cflag),
        .load  (load),
        .tc    (tc)
    );
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [W-1:0] pdata,
    input logic         cflag,
    input logic [W-1:0] count,
    input logic         tc
);
    localparam logic [W-1:0] ONE = W'(1);

    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R2
    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        load |=> (rst || count == $past(pdata)));

    // R6
    a_r6_tc_only_at_zero: assert property (@(posedge clk)
        tc |-> (count == '0));

    // R6
    a_r6_tc_blocked_by_load: assert property (@(posedge clk)
        (load || !cflag) |-> !tc);

    // R7 and R9: at most one downward step per cycle
    a_r9_single_step: assert property (@(posedge clk) disable iff (rst || !seen_clk)
        (!load) |=> (rst || load || count == $past(count) || count == $past(count) - ONE));
endmodule

bind dcnt_top dcnt_checker #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .pdata (pdata),
    .cflag (cflag),
    .count (count),
    .tc    (tc)
);

// File: tb/dcnt_top_test.sv
`timescale 1ns/1ps
module dcnt_top_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_in;
    logic         fb_load;
    logic         fb_en;
    logic         load;
    logic [W-1:0] pdata;
    logic         cflag;
    logic         tick_rise;
    logic         tick_fall;
    logic [W-1:0] count;
    logic         tc;

    int vecs = 0;
    int bad  = 0;

    always #2 clk = ~clk;

    assign load = load_in | (fb_en & fb_load);

    always_ff @(posedge clk) fb_load <= tc;

    dcnt_top #(.W(W)) uut (
        .clk(clk), .rst(rst), .load(load), .pdata(pdata), .cflag(cflag),
        .tick_rise(tick_rise), .tick_fall(tick_fall), .count(count), .tc(tc)
    );

    task automatic chk(input string tag, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic ncyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic preset(input int v);
        pdata = W'(v); load_in = 1'b1; ncyc(1); load_in = 1'b0; ncyc(1);
    endtask

    // one qualified rising edge on tick_rise (tick_fall held low)
    task automatic pulse_rise;
        tick_rise = 1'b1; ncyc(4); tick_rise = 1'b0; ncyc(4);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; load_in = 1'b0; fb_en = 1'b0; pdata = '0; cflag = 1'b1;
        tick_rise = 1'b0; tick_fall = 1'b0;
        ncyc(5);
        chk("R1 reset value", count, 0);
        rst = 1'b0; ncyc(1);
        chk("R6 tc at zero after reset", tc, 1);

        // R7: full descending sweep from every preset
        for (int p = 0; p < 16; p++) begin
            preset(p);
            chk("R2 preset", count, p);
            for (int k = 1; k <= 17; k++) begin
                pulse_rise();
                chk("R7 descend", count, (p - k) & 15);
            end
        end

        // R3 latency: change at negedge, new count after 3rd posedge
        preset(9);
        tick_rise = 1'b1; ncyc(2);
        chk("R3 not yet", count, 9);
        ncyc(1);
        chk("R3 decrement", count, 8);
        tick_rise = 1'b0; ncyc(4);

        // R4: falling edge on tick_fall while tick_rise high
        tick_rise = 1'b1; ncyc(4);
        chk("R3 rise", count, 7);
        for (int k = 1; k <= 5; k++) begin
            tick_fall = 1'b1; ncyc(4);
            chk("R5 rising fall pin ignored", count, 8 - k);
            tick_fall = 1'b0; ncyc(4);
            chk("R4 fall decrement", count, 7 - k);
        end
        tick_rise = 1'b0; ncyc(4);
        chk("R5 falling rise pin ignored", count, 2);

        // R5: blocked edges
        tick_fall = 1'b1; ncyc(4);
        tick_rise = 1'b1; ncyc(4);
        chk("R5 rise blocked by fall high", count, 2);
        tick_rise = 1'b0; ncyc(4);
        tick_fall = 1'b0; ncyc(4);
        chk("R5 fall blocked by rise low", count, 2);

        // R9: both qualified edges in the same cycle
        tick_fall = 1'b1; ncyc(4);
        chk("R9 setup", count, 2);
        tick_rise = 1'b1; tick_fall = 1'b0; ncyc(5);
        chk("R9 single step", count, 1);
        tick_rise = 1'b0; ncyc(4);

        // R2: edges during load discarded
        pdata = 4'd11; load_in = 1'b1;
        tick_rise = 1'b1; ncyc(5); tick_rise = 1'b0; ncyc(5);
        chk("R2 edges ignored under load", count, 11);
        load_in = 1'b0; ncyc(4);
        chk("R2 hold after load", count, 11);

        // R1: reset overrides load and edges
        rst = 1'b1; load_in = 1'b1; tick_rise = 1'b1; ncyc(1);
        chk("R1 overrides load", count, 0);
        load_in = 1'b0; ncyc(4);
        // R10: high level held through reset release
        rst = 1'b0; ncyc(6);
        chk("R10 no count on release", count, 0);
        tick_rise = 1'b0; ncyc(4);

        // R6: tc qualification
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < 2; l++) begin
                cflag = c[0]; load_in = l[0]; pdata = '0; #1;
                chk("R6 tc decode", tc, (c == 1 && l == 0) ? 1 : 0);
                ncyc(1);
            end
        end
        load_in = 1'b0; cflag = 1'b1; ncyc(1);
        preset(3);
        chk("R6 tc low nonzero", tc, 0);

        // R8: divide-by-N with registered feedback
        for (int n = 1; n < 16; n++) begin
            preset(n);
            fb_en = 1'b1;
            for (int rep = 0; rep < 2; rep++) begin
                for (int k = 1; k < n; k++) begin
                    pulse_rise();
                    chk("R8 tc low mid-period", tc, 0);
                end
                tick_rise = 1'b1; ncyc(3);
                chk("R8 tc at period end", tc, 1);
                ncyc(2);
                chk("R8 reload", count, n);
                tick_rise = 1'b0; ncyc(4);
            end
            fb_en = 1'b0; ncyc(2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule